// File: doc/BRIEF.md
# Page Write Collector with In-Page Wrap

This block gathers the data bytes of one serial write transaction into a page-sized holding register and then commits them to a byte-wide memory array in a single timed write cycle. A transaction begins by loading a start address. Each following data byte lands at the current position inside the page, and that position then advances by one. Past the last byte of the page the position wraps back to the first byte of the same page, so surplus bytes overwrite earlier ones and never spill into the neighbouring page. A per-byte valid flag records which positions were actually received.

A commit pulse starts the write cycle. The block holds `busy` high for a programmable settle time counted in system clocks, then sweeps the page once in ascending offset order and issues one memory write for each flagged byte. Positions that were never received keep their old contents. A protection decision made elsewhere arrives as `inhibit`: when it is high at commit, nothing is written. An abort pulse, for example for a STOP in the wrong slot or a repeated START, throws away the collected bytes. While a cycle runs, the block ignores every transaction input.

Top module: `page_write_latch`

## Requirements
- R1: While `rst_n` is low and just after its release, `busy` and `mem_we` are 0. An erased array reads FFh, and a reset writes nothing.
- R2: `addr_load` takes the page number from `start_addr[ADDR_W-1:5]` and the starting offset from `start_addr[4:0]`. Each `byte_vld` stores `byte_data` at the current offset and then increments the offset.
- R3: After offset 31 the offset wraps to 0 of the same page, and a later byte at an offset overwrites the earlier one. All writes of a cycle carry the same `mem_addr[ADDR_W-1:5]`, the loaded page.
- R4: A cycle writes only the offsets that received a byte. Every other byte of the page and of the array is left unchanged, and `mem_we` pulses exactly once for each received offset.
- R5: A commit that is accepted (at least one byte received and `inhibit` low) raises `busy` from the next clock edge for exactly CYCLE_CLKS + 32 clocks. `mem_we` is only ever high while `busy` is high.
- R6: A commit with `inhibit` high writes nothing, leaves `busy` low and discards the collected bytes.
- R7: An `abort` outside a cycle discards the collected bytes, writes nothing and leaves `busy` low.
- R8: A commit with no byte received starts no cycle, so `busy` stays low and nothing is written.
- R9: While `busy` is high, `addr_load`, `byte_vld`, `commit` and `abort` are ignored. The cycle's data and page are not altered, and no byte from that time is kept for later.
- R10: An `addr_load` discards bytes received before it that were not yet committed.
- R11: The input priority outside a cycle is `abort`, then `commit`, then `addr_load`, then `byte_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load start address, begin a new collection |
| start_addr | input | ADDR_W | Start address: page number and offset |
| byte_vld | input | 1 | One data byte is present |
| byte_data | input | DATA_W | Data byte |
| commit | input | 1 | Request the write cycle |
| abort | input | 1 | Discard the collected bytes |
| inhibit | input | 1 | Target is protected, so block the commit |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| busy | output | 1 | Write cycle in progress |

## Verification
A shadow memory built from every `mem_we` strobe is compared against a bench model after each transaction. Directed cases cover the following:
- a single byte at the last offset;
- a short run that crosses the page end, which shows wrap-within-page apart from a carry into the next page;
- a run longer than the page, which shows whether the last byte wins;
- inhibited, aborted, empty and reloaded collections, which separate "discarded" from "written anyway";
- pokes during a running cycle.

Random transactions with random start offsets, lengths up to 40 and random inhibit or abort then mix these cases. Each one checks the page contents, the number of strobes and the exact length of `busy`.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SWEEP = 2'd2
    } pwl_state_e;

endpackage

// File: rtl/pwl_latch.sv
module pwl_latch #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [OFF_W-1:0]      wr_off,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  clr,
    input  logic [OFF_W-1:0]      rd_off,
    output logic [DATA_W-1:0]     rd_data,
    output logic [PAGE_BYTES-1:0] mask
);

    logic [PAGE_BYTES-1:0] mask_d, mask_q;
    logic [DATA_W-1:0]     data_q [PAGE_BYTES];

    // Valid-flag next state: a clear wins over a store.
    always_comb begin
        mask_d = mask_q;
        if (clr) begin
            mask_d = '0;
        end else if (wr_en) begin
            mask_d[wr_off] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    // One byte register per page position.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (wr_en && !clr && (wr_off == OFF_W'(g))) begin
                data_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = data_q[rd_off];
    assign mask    = mask_q;

endmodule

// File: rtl/pwl_timer.sv
module pwl_timer #(
    parameter int CYCLE_CLKS = 40,
    localparam int CNT_W     = $clog2(CYCLE_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    assign done = q.run && (q.cnt == CNT_W'(CYCLE_CLKS - 1));

    always_comb begin
        d = q;
        if (start) begin
            d.run = 1'b1;
            d.cnt = '0;
        end else if (done) begin
            d.run = 1'b0;
            d.cnt = '0;
        end else if (q.run) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/pwl_ctrl.sv
module pwl_ctrl
    import pwl_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  addr_load,
    input  logic [ADDR_W-1:0]     start_addr,
    input  logic                  byte_vld,
    input  logic                  commit,
    input  logic                  abort,
    input  logic                  inhibit,
    input  logic [PAGE_BYTES-1:0] mask,
    input  logic                  tmr_done,
    output logic                  lat_wr,
    output logic [OFF_W-1:0]      lat_off,
    output logic                  lat_clr,
    output logic [OFF_W-1:0]      sweep_off,
    output logic                  tmr_start,
    output logic                  busy,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr
);

    typedef struct packed {
        pwl_state_e        st;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
        logic [OFF_W-1:0]  idx;
    } ctrl_t;

    ctrl_t d, q;

    always_comb begin
        d         = q;
        lat_wr    = 1'b0;
        lat_clr   = 1'b0;
        tmr_start = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (abort) begin
                    lat_clr = 1'b1;
                end else if (commit) begin
                    if ((|mask) && !inhibit) begin
                        d.st      = ST_WAIT;
                        d.idx     = '0;
                        tmr_start = 1'b1;
                    end else begin
                        lat_clr = 1'b1;
                    end
                end else if (addr_load) begin
                    d.page  = start_addr[ADDR_W-1:OFF_W];
                    d.off   = start_addr[OFF_W-1:0];
                    lat_clr = 1'b1;
                end else if (byte_vld) begin
                    lat_wr = 1'b1;
                    d.off  = (q.off == OFF_W'(PAGE_BYTES - 1)) ? '0 : q.off + 1'b1;
                end
            end
            ST_WAIT: begin
                if (tmr_done) begin
                    d.st  = ST_SWEEP;
                    d.idx = '0;
                end
            end
            ST_SWEEP: begin
                if (q.idx == OFF_W'(PAGE_BYTES - 1)) begin
                    d.st    = ST_IDLE;
                    lat_clr = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, page: '0, off: '0, idx: '0};
        end else begin
            q <= d;
        end
    end

    assign lat_off   = q.off;
    assign sweep_off = q.idx;
    assign busy      = (q.st != ST_IDLE);
    assign mem_we    = (q.st == ST_SWEEP) && mask[q.idx];
    assign mem_addr  = {q.page, q.idx};

endmodule

// File: rtl/page_write_latch.sv
module page_write_latch #(
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int CYCLE_CLKS = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              commit,
    input  logic              abort,
    input  logic              inhibit,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy
);

    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic                  lat_wr, lat_clr, tmr_start, tmr_done;
    logic [OFF_W-1:0]      lat_off, sweep_off;
    logic [PAGE_BYTES-1:0] mask;

    pwl_ctrl #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_load  (addr_load),
        .start_addr (start_addr),
        .byte_vld   (byte_vld),
        .commit     (commit),
        .abort      (abort),
        .inhibit    (inhibit),
        .mask       (mask),
        .tmr_done   (tmr_done),
        .lat_wr     (lat_wr),
        .lat_off    (lat_off),
        .lat_clr    (lat_clr),
        .sweep_off  (sweep_off),
        .tmr_start  (tmr_start),
        .busy       (busy),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr)
    );

    pwl_latch #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lat_wr),
        .wr_off  (lat_off),
        .wr_data (byte_data),
        .clr     (lat_clr),
        .rd_off  (sweep_off),
        .rd_data (mem_wdata),
        .mask    (mask)
    );

    pwl_timer #(
        .CYCLE_CLKS (CYCLE_CLKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

endmodule

// File: rtl/pwl_checker.sv
module pwl_checker #(
    parameter int ADDR_W     = 14,
    parameter int PAGE_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic              abort,
    input logic              inhibit,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy
);

    localparam int OFF_W = $clog2(PAGE_BYTES);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!busy && !mem_we)
                else $error("R1: busy or write during reset");
        end
    end

    p_we_in_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_busy_from_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(commit) && !$past(inhibit) && !$past(abort)));

    p_inhibit_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && inhibit && !busy) |=> !busy);

    p_abort_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !busy) |=> !busy);

    p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:OFF_W]));

endmodule

bind page_write_latch pwl_checker #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
) u_pwl_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .abort    (abort),
    .inhibit  (inhibit),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .busy     (busy)
);

// File: tb/page_write_latch_bench.sv
module page_write_latch_bench;

    localparam int AW  = 14;
    localparam int DW  = 8;
    localparam int PB  = 32;
    localparam int CYC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          byte_vld = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          commit = 1'b0;
    logic          abort = 1'b0;
    logic          inhibit = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    page_write_latch #(
        .ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .CYCLE_CLKS(CYC)
    ) u_page_write_latch (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .commit(commit), .abort(abort),
        .inhibit(inhibit), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy)
    );

    // Shadow memory from the write port and the expected memory.
    logic [DW-1:0] dut_mem [int];
    logic [DW-1:0] exp_mem [int];
    int            wcount = 0;

    // Model of the collection in progress.
    bit            pv [PB];
    logic [DW-1:0] pd [PB];
    int            cur_page = 0;
    int            cur_off  = 0;

    always @(negedge clk) begin
        if (mem_we) begin
            dut_mem[int'(mem_addr)] = mem_wdata;
            wcount++;
        end
    end

    function automatic logic [DW-1:0] dut_rd(int a);
        return dut_mem.exists(a) ? dut_mem[a] : 8'hFF;
    endfunction

    function automatic logic [DW-1:0] exp_rd(int a);
        return exp_mem.exists(a) ? exp_mem[a] : 8'hFF;
    endfunction

    function automatic int pend_count();
        int n = 0;
        for (int i = 0; i < PB; i++) n += pv[i];
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_page(input int page, input string req);
        int bad = -1;
        for (int i = 0; i < PB; i++) begin
            if (bad < 0 && dut_rd(page * PB + i) !== exp_rd(page * PB + i)) bad = i;
        end
        if (bad < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, int'(dut_rd(page * PB + bad)), int'(exp_rd(page * PB + bad)));
    endtask

    task automatic clear_pend();
        for (int i = 0; i < PB; i++) pv[i] = 1'b0;
    endtask

    task automatic do_load(input int a);
        @(negedge clk);
        addr_load = 1'b1; start_addr = AW'(a);
        @(negedge clk);
        addr_load = 1'b0;
        cur_page = a / PB; cur_off = a % PB;
        clear_pend();
    endtask

    task automatic send_byte(input logic [DW-1:0] b);
        @(negedge clk);
        byte_vld = 1'b1; byte_data = b;
        @(negedge clk);
        byte_vld = 1'b0;
        pv[cur_off] = 1'b1; pd[cur_off] = b;
        cur_off = (cur_off + 1) % PB;
    endtask

    task automatic do_abort();
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        clear_pend();
    endtask

    // Commit, measure busy length, check the page; optionally poke inputs while busy (R9).
    task automatic do_commit(input bit inh, input bit poke, input string req);
        int  nb;
        int  blen = 0;
        bit  acc;
        nb  = pend_count();
        acc = (nb > 0) && !inh;
        wcount = 0;
        @(negedge clk);
        commit = 1'b1; inhibit = inh;
        @(negedge clk);
        commit = 1'b0; inhibit = 1'b0;
        while (busy && blen < 2 * (CYC + PB)) begin
            blen++;
            if (poke) begin
                addr_load  = (blen % 7 == 1);
                start_addr = AW'($urandom);
                byte_vld   = (blen % 3 == 0);
                byte_data  = DW'($urandom);
                abort      = (blen % 11 == 5);
                commit     = (blen % 13 == 2);
            end
            @(negedge clk);
        end
        addr_load = 1'b0; byte_vld = 1'b0; abort = 1'b0; commit = 1'b0;
        if (acc) begin
            for (int i = 0; i < PB; i++)
                if (pv[i]) exp_mem[cur_page * PB + i] = pd[i];
        end
        check(blen == (acc ? CYC + PB : 0), {req, " R5 busy length"}, blen, acc ? CYC + PB : 0);
        check(wcount == (acc ? nb : 0), {req, " R4 write count"}, wcount, acc ? nb : 0);
        check_page(cur_page, {req, " R4 page contents"});
        clear_pend();
    endtask

    // Confirms that nothing is still collected: an empty commit must not start a cycle.
    task automatic expect_empty(input string req);
        do_commit(1'b0, 1'b0, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R5 watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        clear_pend();
        repeat (3) @(negedge clk);
        check(!busy && !mem_we, "R1 reset outputs", {busy, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_we && wcount == 0, "R1 after release", wcount, 0);

        // R2: single byte at the last offset
        do_load(3 * PB + 31);
        send_byte(8'h5A);
        do_commit(1'b0, 1'b0, "R2 last offset");

        // R3: run crossing the page end wraps within the page
        do_load(10 * PB + 30);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        do_commit(1'b0, 1'b0, "R3 wrap");
        check_page(11, "R3 next page untouched");

        // R3: more than a page, the last byte wins
        do_load(20 * PB + 5);
        for (int i = 0; i < 34; i++) send_byte(DW'(i + 8'h40));
        do_commit(1'b0, 1'b0, "R3 overwrite");
        check(dut_rd(20 * PB + 5) == 8'h60, "R3 offset 5 last byte", int'(dut_rd(20 * PB + 5)), 8'h60);

        // R6: inhibited commit, then the bytes are gone
        do_load(30 * PB);
        send_byte(8'hA1); send_byte(8'hA2);
        do_commit(1'b1, 1'b0, "R6 inhibit");
        expect_empty("R6 discarded");

        // R7: abort
        do_load(31 * PB + 4);
        send_byte(8'hB1);
        do_abort();
        expect_empty("R7 abort");

        // R8: empty commit right after a load
        do_load(40 * PB);
        expect_empty("R8 empty");

        // R10: a reload discards earlier bytes
        do_load(50 * PB + 2);
        send_byte(8'hC1); send_byte(8'hC2);
        do_load(51 * PB + 7);
        send_byte(8'hC3);
        do_commit(1'b0, 1'b0, "R10 reload");
        check_page(50, "R10 old page untouched");

        // R11: abort wins over a simultaneous commit
        do_load(60 * PB);
        send_byte(8'hD1);
        @(negedge clk); abort = 1'b1; commit = 1'b1;
        @(negedge clk); abort = 1'b0; commit = 1'b0;
        check(!busy, "R11 abort over commit", busy, 0);
        clear_pend();
        expect_empty("R11 nothing left");

        // R9: inputs poked while busy are ignored
        do_load(70 * PB + 9);
        send_byte(8'hE1); send_byte(8'hE2);
        do_commit(1'b0, 1'b1, "R9 poke");
        expect_empty("R9 nothing kept");

        // Random mix
        for (int t = 0; t < 24; t++) begin
            int a, n, r;
            a = int'($urandom % (1 << AW));
            n = 1 + int'($urandom % 40);
            r = int'($urandom % 6);
            do_load(a);
            for (int i = 0; i < n; i++) send_byte(DW'($urandom));
            if (r == 0) begin
                do_abort();
                expect_empty("R7 random abort");
            end else begin
                do_commit(r == 1, r == 2, "R4 random");
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule